// File: doc/BRIEF.md
# Token-Chained Readout Controller

This block controls the slave side of block readout for a module that may sit in a chain of modules which a bus master drains as one logical block transfer. It counts incoming triggers against a programmed event level. Once enough events are stored it raises a level flag, and if enabled it raises a latched interrupt. It decodes two read windows. The private window belongs to this module alone. The shared window is common to every module in the chain, and only the module holding the token answers it.

When this module's block has been fully read, the block is retired and the stored count drops by one event level. In a chain, a module that is not last passes the token to its neighbour with a one-cycle pulse. The last module ends the whole transfer with a one-cycle bus error, and the first module reclaims the token when it sees that bus error. A standalone module can end its own transfer with a bus error too. A status bit records that this bus error was issued on purpose. After an interrupt, a single magic data word written to the private window re-arms interrupt generation.

Top module: `blk_chain_readout`

## Requirements
- R1: Each `trig` pulse adds one to `st_count`, which saturates at its maximum. `st_level_flag` is registered and, one cycle after the count changes, equals (count >= `cfg_level`). `st_empty` is high exactly while the count is zero.
- R2: A retired block subtracts `cfg_level` from the count, with a floor of zero. A trigger in the same cycle is added before the subtraction.
- R3: A read of the shared window is acknowledged on `rd_ack` in the same cycle only under all of these conditions: multiblock is enabled (`cfg_ctrl` bit 7), the shared window is enabled (`cfg_mb` bit 0), address bits 31:22 lie within [`cfg_mb`[15:6], `cfg_mb`[31:22]] inclusive, the token is held, `data_avail` is high and `blk_end` is low.
- R4: A read of the private window is acknowledged regardless of the token. The window is enabled by `cfg_priv` bit 0 and matches when address bits 31:22 equal `cfg_priv`[15:6]. The acknowledge also needs `data_avail` high and `blk_end` low.
- R5: During reset, the token is set exactly when multiblock (bit 7) and first-module (bit 8) are both set in `cfg_ctrl`.
- R6: In multiblock mode, a `tok_in` pulse gives the module the token. A shared read with `blk_end` high, while holding the token, retires the block and drops the token. On a module that is not last (`cfg_ctrl` bit 9 low), it also produces a one-cycle `tok_out` in the next cycle.
- R7: On the last module, that retiring read produces a one-cycle `berr` in the next cycle when bus-error response (`cfg_ctrl` bit 6) is set. It also sets `st_berr_flag`.
- R8: A first module in multiblock mode retakes the token one cycle after `berr_in` is high or after it drives `berr` itself. A module that is not first does not retake it.
- R9: With multiblock off, a private read with `blk_end` high retires the block. If bit 6 is set, it also gives a one-cycle `berr` and sets `st_berr_flag`. If bit 6 is clear, there is no bus error.
- R10: With `cfg_ctrl` bit 3 set and the interrupt armed, `irq` rises one cycle after `st_level_flag` is high and stays high. Raising it disarms the interrupt.
- R11: A write of 0x80000000 to the private window clears `irq` and `st_berr_flag` and re-arms the interrupt. Any other write value has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 32 | Control word (bits 3, 6, 7, 8, 9 used) |
| cfg_priv | input | 32 | Private window: bit 0 enable, 15:6 page |
| cfg_mb | input | 32 | Shared window: bit 0 enable, 15:6 lower page, 31:22 upper page |
| cfg_level | input | CNT_W | Events per block |
| trig | input | 1 | One event stored |
| bus_addr | input | 32 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| data_avail | input | 1 | Data path has a word ready |
| blk_end | input | 1 | Current block fully output |
| tok_in | input | 1 | Token from previous module |
| berr_in | input | 1 | Bus error seen on the bus |
| rd_ack | output | 1 | Drive data for this read |
| tok_out | output | 1 | Token pulse to next module |
| berr | output | 1 | Bus error pulse |
| irq | output | 1 | Event-level interrupt |
| st_level_flag | output | 1 | Count reached level |
| st_empty | output | 1 | Count is zero |
| st_berr_flag | output | 1 | Deliberate bus error issued |
| st_token | output | 1 | Token held |
| st_count | output | CNT_W | Stored event count |

## Verification
The bench probes both shared-window page limits and the pages just outside them. A design with an exclusive compare would drop the first or last page, and one with an off-by-one compare would answer a neighbour's address. It drives a block end together with a trigger and a block end below the level. A wrong count order or a wrapping subtraction shows up at once in `st_count`. It runs single, middle, last and one-module chains. A module that retakes the token when it is not first, or fails to retake it after its own bus error, shows a wrong `st_token`. It also writes wrong re-arm values, which a decoder that ignores the data word would treat as a re-arm.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned PAGE_LSB = 22;
  localparam int unsigned PAGE_W   = REG_W - PAGE_LSB;
  localparam int unsigned LO_LSB   = 6;
  localparam logic [REG_W-1:0] REARM_WORD = 32'h8000_0000;

  typedef logic [PAGE_W-1:0] page_t;

  typedef struct packed {
    logic last;
    logic first;
    logic mb_en;
    logic berr_en;
    logic irq_en;
  } ctrl_t;

  function automatic ctrl_t ctrl_decode(input logic [REG_W-1:0] w);
    ctrl_t c;
    c.irq_en  = w[3];
    c.berr_en = w[6];
    c.mb_en   = w[7];
    c.first   = w[8];
    c.last    = w[9];
    return c;
  endfunction

  function automatic page_t addr_page(input logic [REG_W-1:0] a);
    return a[PAGE_LSB +: PAGE_W];
  endfunction

  function automatic page_t win_lower(input logic [REG_W-1:0] w);
    return w[LO_LSB +: PAGE_W];
  endfunction

  function automatic page_t win_upper(input logic [REG_W-1:0] w);
    return w[PAGE_LSB +: PAGE_W];
  endfunction

  function automatic logic page_in_span(input page_t p, input page_t lo, input page_t hi);
    return (p >= lo) && (p <= hi);
  endfunction
endpackage

// File: rtl/chain_win_decode.sv
module chain_win_decode
  import chain_pkg::*;
(
  input  logic [REG_W-1:0] bus_addr,
  input  logic [REG_W-1:0] cfg_priv,
  input  logic [REG_W-1:0] cfg_mb,
  output logic             priv_hit,
  output logic             mb_hit
);
  page_t page;
  assign page = addr_page(bus_addr);

  always_comb begin
    priv_hit = cfg_priv[0] && (page == win_lower(cfg_priv));
    mb_hit   = cfg_mb[0] && page_in_span(page, win_lower(cfg_mb), win_upper(cfg_mb));
  end
endmodule

// File: rtl/chain_evt_counter.sv
module chain_evt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             blk_done,
  input  logic [CNT_W-1:0] level,
  output logic [CNT_W-1:0] count,
  output logic             level_flag,
  output logic             empty
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic inc,
    input logic done, input logic [CNT_W-1:0] lvl);
    logic [CNT_W:0] s;
    s = {1'b0, cur} + {{CNT_W{1'b0}}, inc};
    if (s > CNT_MAX) s = CNT_MAX;
    if (done) s = (s >= {1'b0, lvl}) ? (s - {1'b0, lvl}) : '0;
    return s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      level_flag <= 1'b0;
    end else begin
      count      <= next_count(count, trig, blk_done, level);
      level_flag <= (count >= level);
    end
  end

  assign empty = (count == '0);
endmodule

// File: rtl/chain_token_ctrl.sv
module chain_token_ctrl
  import chain_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  end_shared,
  input  logic  end_priv,
  input  logic  tok_in,
  input  logic  berr_in,
  input  logic  rearm,
  output logic  token,
  output logic  tok_out,
  output logic  berr,
  output logic  berr_flag
);
  logic pass_d, berr_d, retake, grant;

  always_comb begin
    pass_d = end_shared && !ctrl.last;
    berr_d = ctrl.berr_en && ((end_shared && ctrl.last) || end_priv);
    retake = ctrl.mb_en && ctrl.first && (berr_in || berr);
    grant  = (ctrl.mb_en && tok_in) || retake;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      token     <= ctrl.mb_en && ctrl.first;
      tok_out   <= 1'b0;
      berr      <= 1'b0;
      berr_flag <= 1'b0;
    end else begin
      tok_out <= pass_d;
      berr    <= berr_d;
      if (grant)           token <= 1'b1;
      else if (end_shared) token <= 1'b0;
      if (berr_d)          berr_flag <= 1'b1;
      else if (rearm)      berr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/chain_irq_ctrl.sv
module chain_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_en,
  input  logic level_flag,
  input  logic rearm,
  output logic irq
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      armed <= 1'b1;
    end else if (rearm) begin
      irq   <= 1'b0;
      armed <= 1'b1;
    end else if (irq_en && armed && level_flag) begin
      irq   <= 1'b1;
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/blk_chain_readout.sv
module blk_chain_readout
  import chain_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_ctrl,
  input  logic [31:0]      cfg_priv,
  input  logic [31:0]      cfg_mb,
  input  logic [CNT_W-1:0] cfg_level,
  input  logic             trig,
  input  logic [31:0]      bus_addr,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  input  logic             data_avail,
  input  logic             blk_end,
  input  logic             tok_in,
  input  logic             berr_in,
  output logic             rd_ack,
  output logic             tok_out,
  output logic             berr,
  output logic             irq,
  output logic             st_level_flag,
  output logic             st_empty,
  output logic             st_berr_flag,
  output logic             st_token,
  output logic [CNT_W-1:0] st_count
);
  ctrl_t ctrl;
  logic  priv_hit, mb_hit, shared_ok;
  logic  end_shared, end_priv, blk_done, rearm;

  assign ctrl = ctrl_decode(cfg_ctrl);

  chain_win_decode u_win (
    .bus_addr (bus_addr),
    .cfg_priv (cfg_priv),
    .cfg_mb   (cfg_mb),
    .priv_hit (priv_hit),
    .mb_hit   (mb_hit)
  );

  always_comb begin
    shared_ok  = mb_hit && ctrl.mb_en && st_token;
    end_shared = bus_rd && blk_end && shared_ok;
    end_priv   = bus_rd && blk_end && priv_hit && !ctrl.mb_en;
    blk_done   = end_shared || end_priv;
    rearm      = bus_wr && priv_hit && (bus_wdata == REARM_WORD);
    rd_ack     = bus_rd && data_avail && !blk_end && (priv_hit || shared_ok);
  end

  chain_evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .blk_done   (blk_done),
    .level      (cfg_level),
    .count      (st_count),
    .level_flag (st_level_flag),
    .empty      (st_empty)
  );

  chain_token_ctrl u_tok (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .end_shared (end_shared),
    .end_priv   (end_priv),
    .tok_in     (tok_in),
    .berr_in    (berr_in),
    .rearm      (rearm),
    .token      (st_token),
    .tok_out    (tok_out),
    .berr       (berr),
    .berr_flag  (st_berr_flag)
  );

  chain_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_en     (ctrl.irq_en),
    .level_flag (st_level_flag),
    .rearm      (rearm),
    .irq        (irq)
  );
endmodule

// File: rtl/blk_chain_readout_chk.sv
module blk_chain_readout_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             data_avail,
  input logic             blk_end,
  input logic             rd_ack,
  input logic             tok_out,
  input logic             berr,
  input logic             irq,
  input logic             st_level_flag,
  input logic             rearm,
  input logic             blk_done,
  input logic [CNT_W-1:0] st_count
);
  // R3
  ack_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> (bus_rd && data_avail && !blk_end));
  // R6
  tok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |=> !tok_out);
  // R7
  berr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr |=> !berr);
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(st_level_flag));
  // R11
  rearm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !irq);
  // R2
  done_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (st_count <= $past(st_count) + 1));
endmodule

bind blk_chain_readout blk_chain_readout_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_rd        (bus_rd),
  .data_avail    (data_avail),
  .blk_end       (blk_end),
  .rd_ack        (rd_ack),
  .tok_out       (tok_out),
  .berr          (berr),
  .irq           (irq),
  .st_level_flag (st_level_flag),
  .rearm         (rearm),
  .blk_done      (blk_done),
  .st_count      (st_count)
);

// File: tb/blk_chain_readout_bench.sv
module blk_chain_readout_bench;
  localparam int CW = 16;
  localparam logic [31:0] C_IRQ = 32'h008, C_BERR = 32'h040, C_MB = 32'h080,
                          C_FIRST = 32'h100, C_LAST = 32'h200;
  localparam logic [31:0] PRIV_CFG = 32'h0000_1001;
  localparam logic [31:0] MB_CFG   = 32'h40C0_4001;
  localparam logic [31:0] A_PRIV   = 32'h1000_0010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_ctrl = '0, cfg_priv = PRIV_CFG, cfg_mb = MB_CFG, bus_addr = '0, bus_wdata = '0;
  logic [CW-1:0] cfg_level = 16'd3;
  logic trig = 0, bus_rd = 0, bus_wr = 0, data_avail = 0, blk_end = 0, tok_in = 0, berr_in = 0;
  logic rd_ack, tok_out, berr, irq, st_level_flag, st_empty, st_berr_flag, st_token;
  logic [CW-1:0] st_count;

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  int m_cnt; bit m_flag, m_token, m_tok, m_berr, m_bflag, m_irq, m_armed;

  always #5 clk = ~clk;

  blk_chain_readout #(.CNT_W(CW)) u_blk_chain_readout (.*);

  function automatic bit priv_match(input logic [31:0] a);
    return cfg_priv[0] && ((a >> 22) == ((cfg_priv >> 6) & 32'h3FF));
  endfunction
  function automatic bit mb_match(input logic [31:0] a);
    int pg; pg = int'(a >> 22);
    return cfg_mb[0] && pg >= int'((cfg_mb >> 6) & 32'h3FF) && pg <= int'(cfg_mb >> 22);
  endfunction
  function automatic bit m_shared();
    return cfg_ctrl[7] && m_token && mb_match(bus_addr);
  endfunction

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    bit es, ep, done, grant, bd;
    int n;
    if (!rst_n) begin
      m_cnt = 0; m_flag = 0; m_tok = 0; m_berr = 0; m_bflag = 0; m_irq = 0; m_armed = 1;
      m_token = cfg_ctrl[7] && cfg_ctrl[8];
    end else begin
      es = bus_rd && blk_end && m_shared();
      ep = bus_rd && blk_end && priv_match(bus_addr) && !cfg_ctrl[7];
      done = es || ep;
      n = m_cnt + (trig ? 1 : 0);
      if (n > 65535) n = 65535;
      if (done) n = (n >= int'(cfg_level)) ? n - int'(cfg_level) : 0;
      bd = cfg_ctrl[6] && ((es && cfg_ctrl[9]) || ep);
      grant = (cfg_ctrl[7] && tok_in) || (cfg_ctrl[7] && cfg_ctrl[8] && (berr_in || m_berr));
      if (bus_wr && priv_match(bus_addr) && bus_wdata == 32'h8000_0000) begin
        m_irq = 0; m_armed = 1;
        if (!bd) m_bflag = 0;
      end else if (cfg_ctrl[3] && m_armed && m_flag) begin
        m_irq = 1; m_armed = 0;
      end
      if (bd) m_bflag = 1;
      if (grant) m_token = 1; else if (es) m_token = 0;
      m_flag = (m_cnt >= int'(cfg_level));
      m_cnt = n;
      m_tok = es && !cfg_ctrl[9];
      m_berr = bd;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    check("R1 count", st_count, m_cnt);
    check("R1 level flag", st_level_flag, m_flag);
    check("R1 empty", st_empty, m_cnt == 0);
    check("R3 rd_ack", rd_ack, bus_rd && data_avail && !blk_end &&
          (priv_match(bus_addr) || m_shared()));
    check("R5 token", st_token, m_token);
    check("R6 tok_out", tok_out, m_tok);
    check("R7 berr", berr, m_berr);
    check("R9 berr flag", st_berr_flag, m_bflag);
    check("R10 irq", irq, m_irq);
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic idle();
    trig = 0; bus_rd = 0; bus_wr = 0; blk_end = 0; tok_in = 0; berr_in = 0;
  endtask
  task automatic do_reset(input logic [31:0] c, input logic [CW-1:0] lvl);
    cmp_on = 0; idle(); cfg_ctrl = c; cfg_level = lvl; rst_n = 0;
    repeat (3) tick();
    rst_n = 1; cmp_on = 1;
  endtask
  task automatic trig_n(input int n);
    for (int i = 0; i < n; i++) begin trig = 1; tick(); trig = 0; end
  endtask
  task automatic rd_probe(input logic [31:0] a, input bit exp, input string tag);
    bus_addr = a; bus_rd = 1; data_avail = 1; #1;
    check(tag, rd_ack, exp);
    tick(); idle();
  endtask
  task automatic rd_end(input logic [31:0] a);
    bus_addr = a; bus_rd = 1; blk_end = 1; tick(); idle();
  endtask
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick(); idle();
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // single module, interrupt and bus error enabled
    do_reset(C_IRQ | C_BERR, 16'd3);
    check("R1 empty after reset", st_empty, 1);
    check("R5 no token when single", st_token, 0);
    trig_n(3); tick(); tick();
    check("R1 count three", st_count, 3);
    check("R10 irq raised", irq, 1);
    wr(A_PRIV, 32'h0000_1234);
    check("R11 other write ignored", irq, 1);
    wr(A_PRIV, 32'h8000_0001);
    check("R11 near-miss word ignored", irq, 1);
    rd_probe(A_PRIV, 1, "R4 private read acked");
    rd_probe(32'h2000_0000, 0, "R4 outside window");
    rd_probe(32'h4000_0000, 0, "R3 shared ignored in single mode");
    rd_end(A_PRIV);
    check("R9 berr pulse", berr, 1);
    check("R2 count retired", st_count, 0);
    tick();
    check("R9 berr flag kept", st_berr_flag, 1);
    wr(A_PRIV, 32'h8000_0000);
    check("R11 rearm clears irq", irq, 0);
    check("R11 rearm clears berr flag", st_berr_flag, 0);
    // no bus error enable; block end with simultaneous trigger
    cfg_ctrl = C_IRQ;
    trig_n(5); tick(); tick();
    check("R10 irq again after rearm", irq, 1);
    trig = 1; rd_end(A_PRIV);
    check("R2 trigger and retire", st_count, 3);
    check("R9 no berr when disabled", berr, 0);
    cfg_level = 16'd7; rd_end(A_PRIV);
    check("R2 floor at zero", st_count, 0);
    tick(); tick();

    // first, not last
    do_reset(C_MB | C_FIRST | C_BERR, 16'd1);
    check("R5 first owns token", st_token, 1);
    rd_probe(32'h4000_0000, 1, "R3 lower page");
    rd_probe(32'h40C0_0000, 1, "R3 upper page");
    rd_probe(32'h4100_0000, 0, "R3 above upper");
    rd_probe(32'h3FC0_0000, 0, "R3 below lower");
    cfg_mb = MB_CFG & ~32'h1;
    rd_probe(32'h4000_0000, 0, "R3 window disabled");
    cfg_mb = MB_CFG;
    trig_n(1);
    rd_end(32'h4040_0000);
    check("R6 tok_out pulse", tok_out, 1);
    check("R6 token dropped", st_token, 0);
    tick();
    check("R6 tok_out one cycle", tok_out, 0);
    rd_probe(32'h4000_0000, 0, "R3 no token no ack");
    rd_probe(A_PRIV, 1, "R4 private ack without token");
    berr_in = 1; tick(); idle();
    check("R8 first retakes on berr_in", st_token, 1);

    // last, not first
    do_reset(C_MB | C_LAST | C_BERR, 16'd2);
    check("R5 non-first starts without token", st_token, 0);
    tok_in = 1; tick(); idle();
    check("R6 tok_in grants token", st_token, 1);
    trig_n(2);
    rd_end(32'h4000_0000);
    check("R7 last issues berr", berr, 1);
    check("R7 berr flag", st_berr_flag, 1);
    check("R6 token dropped at end", st_token, 0);
    tick();
    check("R8 non-first does not retake", st_token, 0);

    // single-module chain: first and last
    do_reset(C_MB | C_FIRST | C_LAST | C_BERR, 16'd1);
    rd_end(32'h4000_0000);
    check("R7 one-module berr", berr, 1);
    check("R8 token dropped", st_token, 0);
    tick();
    check("R8 retake after own berr", st_token, 1);
    tick(); tick();

    cmp_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule